// File: doc/BRIEF.md
# Head Seek and Recalibrate Sequencer

This block moves a disk drive head from its present track toward a requested track. It moves one track per step and waits a programmable interval between steps. A start pulse begins a command. The command is either a seek to a target track or a recalibration toward track 0. The block issues single-cycle step pulses with a direction level, updates its present-track register, and raises a seek-end flag when the command finishes.

A recalibration steps outward until the drive reports that the head is over track 0, or until a budget of 255 steps is spent. The present track is then forced to 0. If the budget ran out, the block also raises an equipment-check flag. The step interval comes from a 4-bit rate value: the interval is 16 minus that value, in milliseconds, so a rate of 0 gives 16 ms. A millisecond is a parameterised number of clock cycles.

Top module: `head_step_seq`

## Requirements
- R1: After reset the present track is 0, seek end and equipment check are 0, busy is 0 and no step pulse is issued.
- R2: On a seek whose target is above the present track, each step has the direction output at 1 (inward) and adds one to the present track, until the present track equals the target.
- R3: On a seek whose target is below the present track, each step has the direction output at 0 (outward) and subtracts one from the present track, until the present track equals the target.
- R4: A seek whose target equals the present track issues no step. Seek end reads 0 in the cycle after the start pulse is sampled, and reads 1 with busy at 0 in the cycle after that.
- R5: Each step pulse lasts exactly one clock cycle, and the direction output is valid in the same cycle.
- R6: Consecutive step pulses of one command are (16 - rate) * CYC_PER_MS + 1 cycles apart, where rate is sampled at start. A rate of 0 gives a 16 ms interval.
- R7: A recalibration steps outward with the present track held, and stops at the first evaluation that sees track-0 sense high. It then sets the present track to 0 and seek end to 1, and leaves equipment check at 0. If track-0 sense is high at start, no step is issued.
- R8: A recalibration that has issued 255 steps stops at its next evaluation whatever the track-0 sense is. It sets the present track to 0, seek end to 1 and equipment check to 1.
- R9: A start pulse clears seek end and equipment check.
- R10: Busy is high from the cycle after the start pulse until the cycle in which seek end is set. A start pulse while busy is ignored, along with the target and command that come with it.
- R11: The command finishes (seek end rises and busy falls) one step interval, (16 - rate) * CYC_PER_MS + 1 cycles, after its last step pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command start pulse, sampled while idle |
| cmd_recal_i | input | 1 | 1 = recalibrate, 0 = seek |
| target_i | input | TRACK_W | Seek target track |
| trk0_i | input | 1 | Drive reports head over track 0 |
| rate_i | input | RATE_W | Step rate value; interval = 16 - rate ms |
| step_o | output | 1 | Single-cycle step pulse |
| dir_in_o | output | 1 | Step direction: 1 inward, 0 outward |
| track_o | output | TRACK_W | Present-track register |
| seek_end_o | output | 1 | Command complete |
| equip_chk_o | output | 1 | Recalibration spent its step budget |
| busy_o | output | 1 | Command in progress |

## Verification
Two things can fall on the same evaluation cycle at the end of a recalibration: the step budget reaches zero, and track-0 sense goes high. The bench provokes this by raising the sense line just after the 255th step. It then expects equipment check to be set, because budget exhaustion takes priority. The runs where the sense line rises one step earlier must leave the flag clear. A second overlap is a new start pulse that arrives while a seek is still stepping. The bench judges it by the final track, which must equal the first target and not the second.

// File: rtl/hstep_pkg.sv
package hstep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/hstep_ms_tick.sv
module hstep_ms_tick #(
  parameter int CYC_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = $clog2(CYC_PER_MS + 1);

  logic [CW-1:0] cnt_q;

  assign tick = !clr && (cnt_q == CW'(CYC_PER_MS - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + CW'(1);
  end

  assert_tick_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(CYC_PER_MS - 1));
endmodule

// File: rtl/hstep_interval.sv
module hstep_interval #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic             done
);
  logic [LEN_W-1:0] ms_q;

  assign done = tick && (ms_q == len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) ms_q <= '0;
    else if (done)  ms_q <= '0;
    else if (tick)  ms_q <= ms_q + LEN_W'(1);
  end

  assert_ms_below_len_R6: assert property (@(posedge clk) disable iff (rst || clr)
    (len != '0) |-> (ms_q < len));
endmodule

// File: rtl/head_step_seq.sv
module head_step_seq #(
  parameter int TRACK_W     = 8,
  parameter int RATE_W      = 4,
  parameter int CYC_PER_MS  = 1000,
  parameter int STEP_BUDGET = 255
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               cmd_recal_i,
  input  logic [TRACK_W-1:0] target_i,
  input  logic               trk0_i,
  input  logic [RATE_W-1:0]  rate_i,
  output logic               step_o,
  output logic               dir_in_o,
  output logic [TRACK_W-1:0] track_o,
  output logic               seek_end_o,
  output logic               equip_chk_o,
  output logic               busy_o
);
  import hstep_pkg::*;

  localparam int LEN_W    = RATE_W + 1;
  localparam int SPAN     = 2 ** RATE_W;
  localparam int BUDGET_W = $clog2(STEP_BUDGET + 1);

  seq_state_t         state_q;
  logic               recal_q;
  logic [TRACK_W-1:0] tgt_q;
  logic [TRACK_W-1:0] track_q;
  logic [LEN_W-1:0]   len_q;
  logic [BUDGET_W-1:0] budget_q;
  logic               step_q, dir_q, seek_end_q, equip_q;
  logic               wait_clr, ms_tick, wait_done;

  assign wait_clr = (state_q != ST_WAIT);

  hstep_ms_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk(clk), .rst(rst), .clr(wait_clr), .tick(ms_tick)
  );

  hstep_interval #(.LEN_W(LEN_W)) u_ivl (
    .clk(clk), .rst(rst), .clr(wait_clr), .tick(ms_tick),
    .len(len_q), .done(wait_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      recal_q    <= 1'b0;
      tgt_q      <= '0;
      track_q    <= '0;
      len_q      <= '0;
      budget_q   <= '0;
      step_q     <= 1'b0;
      dir_q      <= 1'b0;
      seek_end_q <= 1'b0;
      equip_q    <= 1'b0;
    end else begin
      step_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            recal_q    <= cmd_recal_i;
            tgt_q      <= target_i;
            len_q      <= LEN_W'(SPAN) - LEN_W'(rate_i);
            budget_q   <= BUDGET_W'(STEP_BUDGET);
            seek_end_q <= 1'b0;
            equip_q    <= 1'b0;
            state_q    <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (recal_q) begin
            if (trk0_i || budget_q == '0) begin
              track_q    <= '0;
              seek_end_q <= 1'b1;
              equip_q    <= (budget_q == '0);
              state_q    <= ST_IDLE;
            end else begin
              budget_q <= budget_q - BUDGET_W'(1);
              step_q   <= 1'b1;
              dir_q    <= 1'b0;
              state_q  <= ST_WAIT;
            end
          end else if (tgt_q > track_q) begin
            track_q <= track_q + TRACK_W'(1);
            step_q  <= 1'b1;
            dir_q   <= 1'b1;
            state_q <= ST_WAIT;
          end else if (tgt_q < track_q) begin
            track_q <= track_q - TRACK_W'(1);
            step_q  <= 1'b1;
            dir_q   <= 1'b0;
            state_q <= ST_WAIT;
          end else begin
            seek_end_q <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (wait_done) state_q <= ST_EVAL;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign step_o      = step_q;
  assign dir_in_o    = dir_q;
  assign track_o     = track_q;
  assign seek_end_o  = seek_end_q;
  assign equip_chk_o = equip_q;
  assign busy_o      = (state_q != ST_IDLE);

  assert_step_single_R5: assert property (@(posedge clk) disable iff (rst)
    step_o |=> !step_o);

  assert_seek_inward_R2: assert property (@(posedge clk) disable iff (rst)
    (step_o && !recal_q && dir_in_o) |-> (track_o == $past(track_o) + TRACK_W'(1)));

  assert_seek_outward_R3: assert property (@(posedge clk) disable iff (rst)
    (step_o && !recal_q && !dir_in_o) |-> (track_o == $past(track_o) - TRACK_W'(1)));

  assert_budget_end_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(equip_chk_o) |-> (seek_end_o && track_o == '0 && !busy_o));

  assert_busy_end_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(seek_end_o) |-> !busy_o);

  assert_no_idle_step_R10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !step_o);
endmodule

// File: tb/head_step_seq_tb_top.sv
module head_step_seq_tb_top;
  localparam int TW  = 8;
  localparam int RW  = 4;
  localparam int CPM = 3;
  localparam int BUD = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, cmd_recal_i = 1'b0, trk0_i = 1'b0;
  logic [TW-1:0] target_i = '0;
  logic [RW-1:0] rate_i = '0;
  logic step_o, dir_in_o, seek_end_o, equip_chk_o, busy_o;
  logic [TW-1:0] track_o;

  int n_vec = 0;
  int n_bad = 0;
  int model_track = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  head_step_seq #(.TRACK_W(TW), .RATE_W(RW), .CYC_PER_MS(CPM), .STEP_BUDGET(BUD)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .cmd_recal_i(cmd_recal_i),
    .target_i(target_i), .trk0_i(trk0_i), .rate_i(rate_i),
    .step_o(step_o), .dir_in_o(dir_in_o), .track_o(track_o),
    .seek_end_o(seek_end_o), .equip_chk_o(equip_chk_o), .busy_o(busy_o)
  );

  function automatic int gap_of(input int rate);
    return (16 - rate) * CPM + 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // trk0_after: recal only; number of steps after which track-0 sense rises
  // (0 = high at start). interfere: pulse a second start with another target.
  task automatic run_cmd(input bit recal, input int tgt, input int rate,
                         input int trk0_after, input bit interfere);
    int steps = 0;
    int last_step = -1;
    int cyc = 0;
    int exp_steps, exp_dir;
    bit seen_end = 0;
    @(negedge clk);
    cmd_recal_i = recal;
    target_i = TW'(tgt);
    rate_i = RW'(rate);
    trk0_i = recal && (trk0_after == 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10 busy after start", busy_o, 1);
    chk("R9 seek end cleared", seek_end_o, 0);
    chk("R9 equip cleared", equip_chk_o, 0);
    exp_dir = (tgt > model_track) ? 1 : 0;
    while (!seen_end && cyc < 100000) begin
      if (step_o) begin
        steps++;
        if (recal) chk("R7 recal dir outward", dir_in_o, 0);
        else if (exp_dir == 1) chk("R2 dir inward", dir_in_o, 1);
        else chk("R3 dir outward", dir_in_o, 0);
        if (last_step >= 0) chk("R6 step spacing", cyc - last_step, gap_of(rate));
        last_step = cyc;
        if (!recal) chk("R2 R3 track per step", track_o,
                        model_track + (exp_dir ? steps : -steps));
        if (recal && steps == trk0_after) trk0_i = 1'b1;
        if (interfere && steps == 1) begin
          cmd_recal_i = 1'b0;
          target_i = TW'(tgt + 7);
          start_i = 1'b1;
        end
      end else if (start_i) begin
        start_i = 1'b0;
      end
      if (step_o) begin
        @(negedge clk);
        cyc++;
        chk("R5 step one cycle", step_o, 0);
        if (start_i) start_i = 1'b0;
      end
      if (seek_end_o) begin
        seen_end = 1;
        chk("R10 busy low at end", busy_o, 0);
        if (last_step >= 0) chk("R11 finish after last step", cyc - last_step, gap_of(rate));
      end else begin
        chk("R10 busy while running", busy_o, 1);
        @(negedge clk);
        cyc++;
      end
    end
    if (recal) begin
      exp_steps = (trk0_after < BUD) ? trk0_after : BUD;
      chk("R7 R8 recal steps", steps, exp_steps);
      chk("R7 R8 track zero", track_o, 0);
      chk(trk0_after >= BUD ? "R8 equip set" : "R7 equip clear",
          equip_chk_o, (trk0_after >= BUD) ? 1 : 0);
      model_track = 0;
    end else begin
      exp_steps = (tgt > model_track) ? tgt - model_track : model_track - tgt;
      chk(exp_steps == 0 ? "R4 no step" : "R2 R3 step count", steps, exp_steps);
      chk(interfere ? "R10 start while busy ignored" : "R2 R3 final track", track_o, tgt);
      model_track = tgt;
    end
    chk("R4 seek end set", seek_end_o, 1);
    trk0_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 track", track_o, 0);
    chk("R1 seek end", seek_end_o, 0);
    chk("R1 equip", equip_chk_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 step", step_o, 0);

    // R4 equal target latency
    start_i = 1'b1; cmd_recal_i = 1'b0; target_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R4 seek end low next cycle", seek_end_o, 0);
    chk("R4 busy next cycle", busy_o, 1);
    @(negedge clk);
    chk("R4 seek end set", seek_end_o, 1);
    chk("R4 busy low", busy_o, 0);
    chk("R4 no step", track_o, 0);

    run_cmd(0, 5, 12, 0, 0);   // R2 inward
    run_cmd(0, 2, 0, 0, 0);    // R3 outward, R6 rate 0 = 16 ms
    run_cmd(0, 2, 7, 0, 0);    // R4 equal
    run_cmd(0, 6, 14, 0, 1);   // R10 interfering start
    run_cmd(1, 0, 13, 3, 0);   // R7 track 0 after 3 steps
    run_cmd(0, 4, 15, 0, 0);
    run_cmd(1, 0, 15, 0, 0);   // R7 sense high at start
    run_cmd(0, 3, 15, 0, 0);
    run_cmd(1, 0, 15, 254, 0); // R7 sense just before budget
    run_cmd(0, 1, 15, 0, 0);
    run_cmd(1, 0, 15, 255, 0); // R8 sense and budget together
    run_cmd(0, 2, 15, 0, 0);
    run_cmd(1, 0, 15, 1000, 0); // R8 never sensed

    begin
      int seed = 17;
      void'($urandom(seed));
      for (int i = 0; i < 16; i++) begin
        int t = $urandom_range(0, 20);
        int r = $urandom_range(8, 15);
        if ($urandom_range(0, 3) == 0) run_cmd(1, 0, r, $urandom_range(0, 10), 0);
        else run_cmd(0, t, r, 0, 0);
      end
    end
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (190000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule